// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This block holds a small array of hardware mailboxes through which processor cores exchange short messages and acknowledgements. Every core has a one-hot channel bit. A core takes a mailbox by writing its channel bit into the owner register. It then loads a destination bitmask, a mode, an interrupt mask and a data word, and sets the send register. Each destination core sees an interrupt on its channel. When it has finished, it clears its own bit in the destination bitmask. When the last destination bit goes away, the mailbox either returns an acknowledge interrupt to the owner or simply goes idle, depending on the mode.

Two mode bits shape the completion. Automatic acknowledge turns the last destination clear into an acknowledge request to the owner and leaves the data word untouched. Automatic link hands the message on: when one mailbox completes, the next mailbox starts delivering, so the owner is interrupted only when the final linked mailbox completes. The register bus is a single-cycle synchronous interface. Read data is returned combinationally in the same cycle. Every access carries the one-hot channel bit of the core that issues it.

Top module: `ipc_mailbox`

Address layout (6 bits by default). Bit 5 = 0 selects a mailbox register, with the mailbox index in bits 4:3 and the register in bits 2:0. The register codes are: 0 owner, 1 destination bitmask, 2 mode (bit 0 automatic acknowledge, bit 1 automatic link), 3 interrupt mask, 4 send (bit 0 delivery pending to the destinations, bit 1 acknowledge pending to the owner), 5 data, 6 destination-done strobe (write only, reads as zero). Bit 5 = 1 selects a per-channel status word, with the channel index in bits 1:0. In that status space bit 2 = 0 gives the raw status and bit 2 = 1 gives the masked status. Bit m of a status word belongs to mailbox m.

## Requirements
- R1: An owner write is accepted only when the owner register is zero and the written word is one-hot within the channel bits. Any other nonzero owner write leaves the register unchanged.
- R2: Writes to the destination, mode, mask, send and data registers take effect only when the issuing channel equals the current owner. Otherwise they are ignored.
- R3: A zero written to the owner register by the owner releases the mailbox and clears the send register and the data word in the same cycle. A zero written by any other channel is ignored.
- R4: A destination-done write clears only the issuing channel's bit. It has effect only while send bit 0 is set and that bit is present in the destination bitmask.
- R5: Raw status bit m of channel c is 1 when send bit 0 is set and destination bit c is set, or when send bit 1 is set and channel c owns mailbox m.
- R6: Masked status is the raw status ANDed with mask bit c of each mailbox. irq[c] is the OR of channel c's masked status over all mailboxes.
- R7: With automatic acknowledge set and link clear, clearing the last destination bit sets send to 2'b10 in one step and leaves the data word unchanged.
- R8: With both mode bits clear, clearing the last destination bit sets send to 2'b00.
- R9: With link set on mailbox m (not the last mailbox), clearing its last destination bit sets send of mailbox m to 2'b00 and send of mailbox m+1 to 2'b01. No acknowledge reaches the owner until the final mailbox completes.
- R10: An owner that keeps its owner register set can load new destination, mode, mask and data values and send again without claiming the mailbox again.
- R11: After reset every register is zero and every irq output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busChan | input | NUM_CH | One-hot channel bit of the issuing core |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, same cycle |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The assertions check the following on every cycle:
- owner exclusivity, and that the owner changes only by release;
- that a release leaves send and data cleared;
- the send transitions produced by a last destination clear in each mode;
- that no interrupt is raised while every send register is zero.

Several behaviours only show up in the bench's scenarios: rejected writes from foreign channels, the mask gating between raw and masked status, a re-send by a retained owner, and the full two-mailbox chain in which the owner sees no acknowledge until the second mailbox finishes. The bench's reference model also tracks every interrupt line cycle by cycle through all of these sequences.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int REG_W = 3;

  typedef enum logic [REG_W-1:0] {
    REG_SRC  = 3'd0,
    REG_DST  = 3'd1,
    REG_MODE = 3'd2,
    REG_MASK = 3'd3,
    REG_SEND = 3'd4,
    REG_DATA = 3'd5,
    REG_DCLR = 3'd6
  } mboxReg_e;

  // Strobes from control to datapath for one mailbox
  typedef struct packed {
    logic claim;
    logic drop;
    logic wrDst;
    logic wrMode;
    logic wrMask;
    logic wrSend;
    logic wrData;
    logic clrDst;
    logic finAck;
    logic finIdle;
    logic linkOut;
    logic linkIn;
  } mboxStb_t;
endpackage

// File: rtl/ipc_mailbox_ctrl.sv
module ipc_mailbox_ctrl
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                               busValid,
  input  logic                               busWrite,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [NUM_CH-1:0]                  busChan,
  input  logic [DATA_W-1:0]                  busWdata,
  input  logic [NUM_MBOX-1:0][NUM_CH-1:0]    srcAll,
  input  logic [NUM_MBOX-1:0][NUM_CH-1:0]    dstAll,
  input  logic [NUM_MBOX-1:0][1:0]           modeAll,
  input  logic [NUM_MBOX-1:0][1:0]           sendAll,
  output mboxStb_t [NUM_MBOX-1:0]            stb
);
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

  logic            mboxWr;
  logic [MB_W-1:0] idx;
  mboxReg_e        regSel;
  logic            oneHotVal;
  logic [NUM_MBOX-1:0] linkReq;

  assign mboxWr    = busValid && busWrite && !busAddr[ADDR_W-1];
  assign idx       = busAddr[REG_W +: MB_W];
  assign regSel    = mboxReg_e'(busAddr[REG_W-1:0]);
  assign oneHotVal = (busWdata[DATA_W-1:NUM_CH] == '0) && $onehot(busWdata[NUM_CH-1:0]);

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    logic sel, owner, hit, last, linkFromPrev;

    assign sel   = mboxWr && (idx == MB_W'(m));
    assign owner = (srcAll[m] != '0) && (srcAll[m] == busChan);
    assign hit   = sel && (regSel == REG_DCLR) && sendAll[m][0] && ((dstAll[m] & busChan) != '0);
    assign last  = hit && ((dstAll[m] & ~busChan) == '0);

    if (m < NUM_MBOX - 1) begin : g_link
      assign linkReq[m] = last && modeAll[m][1];
    end else begin : g_nolink
      assign linkReq[m] = 1'b0;
    end

    if (m > 0) begin : g_prev
      assign linkFromPrev = linkReq[m-1];
    end else begin : g_first
      assign linkFromPrev = 1'b0;
    end

    always_comb begin
      stb[m]         = '0;
      stb[m].claim   = sel && (regSel == REG_SRC) && (srcAll[m] == '0) && oneHotVal;
      stb[m].drop    = sel && (regSel == REG_SRC) && owner && (busWdata == '0);
      stb[m].wrDst   = sel && owner && (regSel == REG_DST);
      stb[m].wrMode  = sel && owner && (regSel == REG_MODE);
      stb[m].wrMask  = sel && owner && (regSel == REG_MASK);
      stb[m].wrSend  = sel && owner && (regSel == REG_SEND);
      stb[m].wrData  = sel && owner && (regSel == REG_DATA);
      stb[m].clrDst  = hit;
      stb[m].linkOut = linkReq[m];
      stb[m].finAck  = last && !linkReq[m] && modeAll[m][0];
      stb[m].finIdle = last && !linkReq[m] && !modeAll[m][0];
      stb[m].linkIn  = linkFromPrev;
    end
  end
endmodule

// File: rtl/ipc_mailbox_regs.sv
module ipc_mailbox_regs
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [NUM_CH-1:0]                  busChan,
  input  logic [DATA_W-1:0]                  busWdata,
  input  mboxStb_t [NUM_MBOX-1:0]            stb,
  output logic [NUM_MBOX-1:0][NUM_CH-1:0]    srcAll,
  output logic [NUM_MBOX-1:0][NUM_CH-1:0]    dstAll,
  output logic [NUM_MBOX-1:0][1:0]           modeAll,
  output logic [NUM_MBOX-1:0][1:0]           sendAll,
  output logic [NUM_MBOX-1:0][DATA_W-1:0]    dataAll,
  output logic [NUM_CH-1:0]                  irq,
  output logic [DATA_W-1:0]                  busRdata
);
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_MBOX-1:0][NUM_CH-1:0] maskAll;
  logic [NUM_MBOX-1:0][NUM_CH-1:0] rawAll;
  logic [NUM_CH-1:0][NUM_MBOX-1:0] rawByCh;
  logic [NUM_CH-1:0][NUM_MBOX-1:0] maskedByCh;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    always_ff @(posedge clk) begin
      if (rst) begin
        srcAll[m]  <= '0;
        dstAll[m]  <= '0;
        modeAll[m] <= '0;
        maskAll[m] <= '0;
        sendAll[m] <= '0;
        dataAll[m] <= '0;
      end else begin
        if (stb[m].claim)  srcAll[m]  <= busWdata[NUM_CH-1:0];
        if (stb[m].wrDst)  dstAll[m]  <= busWdata[NUM_CH-1:0];
        if (stb[m].clrDst) dstAll[m]  <= dstAll[m] & ~busChan;
        if (stb[m].wrMode) modeAll[m] <= busWdata[1:0];
        if (stb[m].wrMask) maskAll[m] <= busWdata[NUM_CH-1:0];
        if (stb[m].wrSend) sendAll[m] <= busWdata[1:0];
        if (stb[m].wrData) dataAll[m] <= busWdata;
        if (stb[m].finAck) sendAll[m] <= 2'b10;
        if (stb[m].finIdle || stb[m].linkOut) sendAll[m] <= 2'b00;
        if (stb[m].linkIn) sendAll[m] <= 2'b01;
        if (stb[m].drop) begin
          srcAll[m]  <= '0;
          sendAll[m] <= '0;
          dataAll[m] <= '0;
        end
      end
    end

    assign rawAll[m] = (sendAll[m][0] ? dstAll[m] : '0) | (sendAll[m][1] ? srcAll[m] : '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign rawByCh[c][m]    = rawAll[m][c];
      assign maskedByCh[c][m] = rawAll[m][c] & maskAll[m][c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    assign irq[c] = |maskedByCh[c];
  end

  // Same-cycle read mux
  logic [MB_W-1:0] idx;
  logic [CH_W-1:0] chSel;
  mboxReg_e        regSel;

  assign idx    = busAddr[REG_W +: MB_W];
  assign chSel  = busAddr[CH_W-1:0];
  assign regSel = mboxReg_e'(busAddr[REG_W-1:0]);

  always_comb begin
    busRdata = '0;
    if (busAddr[ADDR_W-1]) begin
      busRdata[NUM_MBOX-1:0] = busAddr[CH_W] ? maskedByCh[chSel] : rawByCh[chSel];
    end else begin
      case (regSel)
        REG_SRC:  busRdata[NUM_CH-1:0] = srcAll[idx];
        REG_DST:  busRdata[NUM_CH-1:0] = dstAll[idx];
        REG_MODE: busRdata[1:0]        = modeAll[idx];
        REG_MASK: busRdata[NUM_CH-1:0] = maskAll[idx];
        REG_SEND: busRdata[1:0]        = sendAll[idx];
        REG_DATA: busRdata             = dataAll[idx];
        default:  busRdata             = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 1 + ((NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NUM_CH-1:0] busChan,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irq
);
  mboxStb_t [NUM_MBOX-1:0]          stb;
  logic [NUM_MBOX-1:0][NUM_CH-1:0]  srcAll;
  logic [NUM_MBOX-1:0][NUM_CH-1:0]  dstAll;
  logic [NUM_MBOX-1:0][1:0]         modeAll;
  logic [NUM_MBOX-1:0][1:0]         sendAll;
  logic [NUM_MBOX-1:0][DATA_W-1:0]  dataAll;

  ipc_mailbox_ctrl #(
    .NUM_MBOX(NUM_MBOX), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busChan(busChan), .busWdata(busWdata),
    .srcAll(srcAll), .dstAll(dstAll), .modeAll(modeAll), .sendAll(sendAll),
    .stb(stb)
  );

  ipc_mailbox_regs #(
    .NUM_MBOX(NUM_MBOX), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busChan(busChan),
    .busWdata(busWdata), .stb(stb),
    .srcAll(srcAll), .dstAll(dstAll), .modeAll(modeAll), .sendAll(sendAll),
    .dataAll(dataAll), .irq(irq), .busRdata(busRdata)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              busValid,
  input logic                              busWrite,
  input logic [ADDR_W-1:0]                 busAddr,
  input logic [NUM_CH-1:0]                 busChan,
  input logic [NUM_MBOX-1:0][NUM_CH-1:0]   srcAll,
  input logic [NUM_MBOX-1:0][NUM_CH-1:0]   dstAll,
  input logic [NUM_MBOX-1:0][1:0]          modeAll,
  input logic [NUM_MBOX-1:0][1:0]          sendAll,
  input logic [NUM_MBOX-1:0][DATA_W-1:0]   dataAll,
  input logic [NUM_CH-1:0]                 irq
);
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

  logic doneWr;
  assign doneWr = busValid && busWrite && !busAddr[ADDR_W-1] &&
                  (busAddr[REG_W-1:0] == REG_DCLR);

  // R6: nothing pending anywhere means no interrupt
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (sendAll == '0) |-> (irq == '0));

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    logic lastDone;
    assign lastDone = doneWr && (busAddr[REG_W +: MB_W] == MB_W'(m)) &&
                      sendAll[m][0] && (dstAll[m] == busChan) && (busChan != '0);

    a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
      $onehot0(srcAll[m]));

    a_r1_owner_held: assert property (@(posedge clk) disable iff (rst)
      (srcAll[m] != '0) |=> ((srcAll[m] == $past(srcAll[m])) || (srcAll[m] == '0)));

    a_r3_release_clears: assert property (@(posedge clk) disable iff (rst)
      (srcAll[m] != '0) |=> ((srcAll[m] != '0) || ((sendAll[m] == '0) && (dataAll[m] == '0))));

    a_r7_auto_ack: assert property (@(posedge clk) disable iff (rst)
      (lastDone && (modeAll[m] == 2'b01)) |=> ((sendAll[m] == 2'b10) && $stable(dataAll[m])));

    a_r8_plain_finish: assert property (@(posedge clk) disable iff (rst)
      (lastDone && (modeAll[m] == 2'b00)) |=> (sendAll[m] == 2'b00));

    if (m < NUM_MBOX - 1) begin : g_link
      a_r9_chain_handoff: assert property (@(posedge clk) disable iff (rst)
        (lastDone && modeAll[m][1]) |=> ((sendAll[m] == 2'b00) && (sendAll[m+1] == 2'b01)));
    end
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NUM_MBOX(NUM_MBOX), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busChan(busChan),
  .srcAll(srcAll), .dstAll(dstAll), .modeAll(modeAll), .sendAll(sendAll),
  .dataAll(dataAll), .irq(irq)
);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        busValid, busWrite;
  logic [5:0]  busAddr;
  logic [3:0]  busChan;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [3:0]  irq;

  int checks = 0;
  int errs   = 0;

  // Behavioural reference state
  logic [3:0]  mSrc [4];
  logic [3:0]  mDst [4];
  logic [1:0]  mMode[4];
  logic [3:0]  mMask[4];
  logic [1:0]  mSend[4];
  logic [31:0] mData[4];

  always #2 clk = ~clk;  // 250 MHz

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busChan(busChan), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  function automatic void modelReset();
    for (int m = 0; m < 4; m++) begin
      mSrc[m] = 0; mDst[m] = 0; mMode[m] = 0; mMask[m] = 0; mSend[m] = 0; mData[m] = 0;
    end
  endfunction

  function automatic void modelWrite(input logic [3:0] ch, input int addr, input logic [31:0] wd);
    int m, r;
    bit owner, oneHot;
    if (addr >= 32) return;
    m = addr / 8;
    r = addr % 8;
    owner  = (mSrc[m] != 0) && (mSrc[m] == ch);
    oneHot = (wd != 0) && (wd < 16) && ((wd & (wd - 1)) == 0);
    case (r)
      0: if (mSrc[m] == 0 && oneHot) mSrc[m] = wd[3:0];
         else if (owner && wd == 0) begin mSrc[m] = 0; mSend[m] = 0; mData[m] = 0; end
      1: if (owner) mDst[m]  = wd[3:0];
      2: if (owner) mMode[m] = wd[1:0];
      3: if (owner) mMask[m] = wd[3:0];
      4: if (owner) mSend[m] = wd[1:0];
      5: if (owner) mData[m] = wd;
      6: if (mSend[m][0] && (mDst[m] & ch) != 0) begin
           mDst[m] = mDst[m] & ~ch;
           if (mDst[m] == 0) begin
             if (mMode[m][1] && m < 3) begin mSend[m] = 0; mSend[m+1] = 2'b01; end
             else if (mMode[m][0]) mSend[m] = 2'b10;
             else mSend[m] = 2'b00;
           end
         end
      default: ;
    endcase
  endfunction

  function automatic logic [3:0] modelIrq();
    logic [3:0] v = 0;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        if (((mSend[m][0] && mDst[m][c]) || (mSend[m][1] && mSrc[m][c])) && mMask[m][c]) v[c] = 1'b1;
    return v;
  endfunction

  function automatic void check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // Cycle-by-cycle comparison against the reference model (R6)
  always @(negedge clk) begin
    if (!rst) check({28'b0, irq}, {28'b0, modelIrq()}, "R6 per-cycle irq vs model");
  end

  task automatic wr(input logic [3:0] ch, input int addr, input logic [31:0] wd);
    @(negedge clk);
    busValid = 1; busWrite = 1; busChan = ch; busAddr = addr[5:0]; busWdata = wd;
    @(posedge clk);
    modelWrite(ch, addr, wd);
    #1 busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = addr[5:0];
    #1 check(busRdata, exp, tag);
    busValid = 0;
  endtask

  task automatic chkIrq(input logic [3:0] exp, input string tag);
    @(negedge clk);
    #1 check({28'b0, irq}, {28'b0, exp}, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    modelReset();
    rst = 1; busValid = 0; busWrite = 0; busAddr = 0; busChan = 0; busWdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R11 reset state
    rd(0, 0, "R11 owner after reset");
    rd(4, 0, "R11 send after reset");
    chkIrq(4'b0000, "R11 irq after reset");

    // R1 claim rules
    wr(4'b0001, 0, 32'h1);
    rd(0, 32'h1, "R1 claim by channel 0");
    wr(4'b0010, 0, 32'h2);
    rd(0, 32'h1, "R1 second claim ignored");
    wr(4'b0001, 8, 32'h3);
    rd(8, 0, "R1 non-one-hot claim ignored");

    // R2 foreign write ignored, then owner loads a message
    wr(4'b0010, 5, 32'hDEAD_BEEF);
    rd(5, 0, "R2 foreign data write ignored");
    wr(4'b0001, 5, 32'hA5A5_0001);
    wr(4'b0001, 1, 32'h6);
    wr(4'b0001, 2, 32'h1);
    wr(4'b0001, 3, 32'h7);
    wr(4'b0001, 4, 32'h1);
    rd(33, 32'h1, "R5 raw status channel 1");
    rd(32, 32'h0, "R5 raw status channel 0 idle");
    rd(38, 32'h1, "R6 masked status channel 2");
    chkIrq(4'b0110, "R6 irq to both destinations");

    // R4 / R7 destination completion with automatic acknowledge
    wr(4'b0001, 6, 32'h0);
    rd(1, 32'h6, "R4 done from non-destination ignored");
    wr(4'b0010, 6, 32'h0);
    rd(1, 32'h4, "R4 only own bit cleared");
    rd(4, 32'h1, "R4 still pending to last destination");
    wr(4'b0100, 6, 32'h0);
    rd(4, 32'h2, "R7 send becomes acknowledge");
    rd(5, 32'hA5A5_0001, "R7 data unchanged by acknowledge");
    chkIrq(4'b0001, "R7 acknowledge irq to owner");

    // R6 mask gating
    wr(4'b0001, 3, 32'h6);
    chkIrq(4'b0000, "R6 masked acknowledge");
    rd(32, 32'h1, "R6 raw still set");
    rd(36, 32'h0, "R6 masked cleared");

    // R10 re-send while owning, R8 plain completion
    wr(4'b0001, 4, 32'h0);
    wr(4'b0001, 1, 32'h2);
    wr(4'b0001, 2, 32'h0);
    wr(4'b0001, 3, 32'h7);
    wr(4'b0001, 5, 32'h0000_1234);
    wr(4'b0001, 4, 32'h1);
    rd(0, 32'h1, "R10 ownership retained");
    chkIrq(4'b0010, "R10 second message delivered");
    wr(4'b0010, 6, 32'h0);
    rd(4, 32'h0, "R8 plain completion goes idle");
    chkIrq(4'b0000, "R8 no acknowledge irq");

    // R3 release
    wr(4'b0001, 4, 32'h2);
    chkIrq(4'b0001, "R3 owner ack before release");
    wr(4'b0010, 0, 32'h0);
    rd(0, 32'h1, "R3 foreign release ignored");
    wr(4'b0010, 5, 32'h0);
    rd(5, 32'h1234, "R2 foreign data write ignored again");
    wr(4'b0001, 0, 32'h0);
    rd(0, 32'h0, "R3 owner cleared");
    rd(4, 32'h0, "R3 send cleared");
    rd(5, 32'h0, "R3 data cleared");
    wr(4'b0010, 0, 32'h2);
    rd(0, 32'h2, "R1 claim after release");

    // R9 linked mailboxes 1 -> 2
    wr(4'b0001, 8, 32'h1);
    wr(4'b0001, 16, 32'h1);
    wr(4'b0001, 9, 32'h2);
    wr(4'b0001, 10, 32'h3);
    wr(4'b0001, 11, 32'h7);
    wr(4'b0001, 13, 32'h11);
    wr(4'b0001, 17, 32'h2);
    wr(4'b0001, 18, 32'h1);
    wr(4'b0001, 19, 32'h7);
    wr(4'b0001, 21, 32'h22);
    wr(4'b0001, 12, 32'h1);
    rd(33, 32'h2, "R9 first link message pending");
    wr(4'b0010, 14, 32'h0);
    rd(12, 32'h0, "R9 first mailbox idle after hand-off");
    rd(20, 32'h1, "R9 second mailbox delivering");
    rd(33, 32'h4, "R9 destination sees second mailbox");
    chkIrq(4'b0010, "R9 owner not yet acknowledged");
    wr(4'b0010, 22, 32'h0);
    rd(20, 32'h2, "R9 final mailbox acknowledges");
    rd(32, 32'h4, "R9 owner raw status from final mailbox");
    rd(13, 32'h11, "R9 first data unchanged");
    chkIrq(4'b0001, "R9 single acknowledge irq");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule